// File: doc/BRIEF.md
# Phase-Aligned Burst Clock Generator

This block drives a clock pin for a serial memory or card interface. It produces a burst of clock pulses at a divider that can be changed at runtime. While the block is enabled, an internal period counter runs freely. A request for a burst is only acted on at the end of a period, so the first edge of the burst falls at a time that software can compute from the divider and from the phase at which the request was written.

The block also runs a lead-in timer, loaded by the same write. That timer lets a separate data shifter start exactly in step with the first clock edge. The lead-in value is supplied again with every burst. A transfer that starts with a framing bit can therefore use one value, and a resumed transfer, such as a checksum that follows a data block, can use another. A one-cycle marker flags the first active clock transition of every burst.

Top module: `clkb_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `sclk_o`, `busy_o`, `first_edge_o` and `data_start_o` are all 0.
- R2: Counting cycles from the first cycle in which `en_i` is sampled high (cycle 0), the cycle index modulo D is the period phase, where D is the effective divider. A write accepted in cycle c at phase p gives its first active clock transition in cycle c+G+2, where G = D-1-p if p < D-1 and G = D if p = D-1.
- R3: A write made in cycle 0 gives its first active transition in cycle D+1. This is the earliest possible transition, and it falls in the second period.
- R4: A burst of length N gives exactly N pulses, one per period. Each pulse holds `sclk_o` at the inverse of `idle_hi_i` for ceil(D/2) cycles. At all other times `sclk_o` equals `idle_hi_i`. An odd divider therefore makes the active phase the longer half.
- R5: A `div_i` value of 0 or 1 behaves exactly as a divider of 2.
- R6: `busy_o` rises in the cycle after an accepted write. It stays high through the period boundary that ends the last pulse, which is cycle c+G+N*D, and falls in the next cycle.
- R7: A write is ignored in each of these cases: `busy_o` is high, `en_i` is low, or `burst_len_i` is 0. An ignored write changes neither the pulse count nor the data-start timing.
- R8: For a lead-in L > 0 written with the burst, `data_start_o` is high for exactly one cycle, cycle c+L. With L = 0 no strobe is produced.
- R9: `first_edge_o` is high for exactly one cycle per burst. That cycle is the one in which `sclk_o` first leaves its idle level.
- R10: When `en_i` is sampled low, the block aborts. In the next cycle `busy_o` is 0 and `sclk_o` is at idle, and the period phase restarts from 0 at the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Runs the period counter while high |
| div_i | input | DIV_W | Clock divider in system cycles (values below 2 are clamped to 2) |
| idle_hi_i | input | 1 | Idle level of the clock pin (1 = idles high) |
| burst_we_i | input | 1 | Write strobe that requests a burst |
| burst_len_i | input | CNT_W | Number of pulses in the burst |
| lead_i | input | LEAD_W | Lead-in delay, in cycles, to the data-start strobe |
| sclk_o | output | 1 | Clock pin |
| busy_o | output | 1 | Burst pending or running |
| first_edge_o | output | 1 | Marks the first active transition of the burst |
| data_start_o | output | 1 | Start strobe for the data shifter |

## Verification
The bench writes bursts at every phase of the period. This includes the last phase, where a design that took the same-cycle boundary would start one full period early. It covers odd dividers and clamped dividers. A wrong high-phase split shows up there as a shortened active level, and a missing clamp as a stuck or runaway phase. Directed cases send a second write in the middle of a burst, a write while disabled, and a zero-length write. A design that accepted any of these would emit extra pulses or a stray data-start strobe. A final case drops enable in the middle of a burst, where a design that did not gate the pulse level would leave the pin active for one more cycle.

// File: rtl/clkb_pkg.sv
// Shared types for the burst clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package clkb_pkg;

    // Sequencer state: no burst, waiting for a period boundary, emitting pulses
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_st_t;

endpackage

// File: rtl/clkb_period.sv
// Free-running period counter. Counts phases 0..D-1 while enabled and holds
// phase 0 while disabled. Flags the last cycle of each period and the
// active-level window of a pulse (the first ceil(D/2) phases).
// Assumes: div_i is held stable while a burst runs.
module clkb_period #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bnd_o,
    output logic             hi_o
);
    logic [DIV_W-1:0] dclamp;
    logic [DIV_W-1:0] dmax;
    logic [DIV_W:0]   hlen;
    logic [DIV_W-1:0] phase_q;

    // Clamp the divider to at least 2 and derive the last phase and the active-window length
    always_comb begin
        dclamp = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        dmax   = dclamp - DIV_W'(1);
        hlen   = ({1'b0, dclamp} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
    end

    // Advance the phase while enabled, wrapping at the end of the period
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q <= '0;
        end else if (phase_q >= dmax) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

    assign bnd_o = en_i && (phase_q >= dmax);
    assign hi_o  = ({1'b0, phase_q} < hlen);

endmodule

// File: rtl/clkb_seq.sv
// Burst sequencer. Accepts a burst write when idle, waits for the next
// period boundary, then emits one pulse per period until the count runs out.
// Drives the registered clock pin and the first-edge marker.
// Assumes: bnd_i and hi_i come from clkb_period on the same clock.
module clkb_seq
    import clkb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             bnd_i,
    input  logic             hi_i,
    input  logic             idle_hi_i,
    output logic             we_acc_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             first_o
);
    seq_st_t          st_q;
    logic [CNT_W-1:0] remain_q;
    logic             first_pend_q;
    logic             sclk_q;
    logic             first_q;
    logic             lvl;

    // Accept a write only when enabled, idle and non-empty; gate the pulse level by enable
    always_comb begin
        we_acc_o = en_i && we_i && (st_q == SEQ_IDLE) && (len_i != '0);
        lvl      = en_i && (st_q == SEQ_RUN) && hi_i;
    end

    // Register the pin level and the first-edge marker together so that they line up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            sclk_q  <= idle_hi_i ^ lvl;
            first_q <= lvl && first_pend_q;
        end
    end

    // Burst state machine: idle -> wait for boundary -> run N periods
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= SEQ_IDLE;
            remain_q     <= '0;
            first_pend_q <= 1'b0;
        end else if (!en_i) begin
            st_q         <= SEQ_IDLE;
            first_pend_q <= 1'b0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (we_acc_o) begin
                        remain_q <= len_i;
                        st_q     <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (bnd_i) begin
                        st_q         <= SEQ_RUN;
                        first_pend_q <= 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (lvl && first_pend_q) begin
                        first_pend_q <= 1'b0;
                    end
                    if (bnd_i) begin
                        if (remain_q == CNT_W'(1)) begin
                            st_q <= SEQ_IDLE;
                        end else begin
                            remain_q <= remain_q - CNT_W'(1);
                        end
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign sclk_o  = sclk_q;
    assign busy_o  = (st_q != SEQ_IDLE);
    assign first_o = first_q;

    // Dropping enable aborts the burst and parks the pin at idle
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && (sclk_o == $past(idle_hi_i)))); // R10

    // No burst in flight means no pulse on the pin
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> (sclk_o == $past(idle_hi_i))); // R4

    // A running burst cannot end away from a period boundary
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && busy_o && !bnd_i) |=> busy_o); // R6

    // A write while busy leaves the remaining count untouched
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && busy_o && we_i && !bnd_i) |=> $stable(remain_q)); // R7

endmodule

// File: rtl/clkb_lead.sv
// Lead-in timer. Loaded by each accepted burst write, it emits one strobe
// exactly L cycles after the write cycle. A load of 0 yields no strobe.
// Assumes: load_i is a single-cycle pulse.
module clkb_lead #(
    parameter int LEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [LEAD_W-1:0] lead_i,
    output logic              start_o
);
    logic [LEAD_W-1:0] cnt_q;
    logic              armed_q;

    // Count down from the loaded lead-in and disarm once the strobe is issued
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= lead_i;
            armed_q <= (lead_i != '0);
        end else if (armed_q) begin
            cnt_q <= cnt_q - LEAD_W'(1);
            if (cnt_q == LEAD_W'(1)) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign start_o = armed_q && (cnt_q == LEAD_W'(1));

    // A lead-in of one puts the strobe in the very next cycle
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && load_i && (lead_i == LEAD_W'(1))) |=> start_o); // R8

endmodule

// File: rtl/clkb_gen.sv
// Phase-aligned burst clock generator (top level). Ties the free-running
// period counter, the burst sequencer and the lead-in timer together.
// Assumes: div_i and idle_hi_i are stable during a burst.
module clkb_gen #(
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 8,
    parameter int LEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              idle_hi_i,
    input  logic              burst_we_i,
    input  logic [CNT_W-1:0]  burst_len_i,
    input  logic [LEAD_W-1:0] lead_i,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              first_edge_o,
    output logic              data_start_o
);
    logic bnd;
    logic hi;
    logic we_acc;

    clkb_period #(.DIV_W(DIV_W)) i_period (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .div_i (div_i),
        .bnd_o (bnd),
        .hi_o  (hi)
    );

    clkb_seq #(.CNT_W(CNT_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .we_i      (burst_we_i),
        .len_i     (burst_len_i),
        .bnd_i     (bnd),
        .hi_i      (hi),
        .idle_hi_i (idle_hi_i),
        .we_acc_o  (we_acc),
        .sclk_o    (sclk_o),
        .busy_o    (busy_o),
        .first_o   (first_edge_o)
    );

    clkb_lead #(.LEAD_W(LEAD_W)) i_lead (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .load_i  (we_acc),
        .lead_i  (lead_i),
        .start_o (data_start_o)
    );

    // The first-edge marker coincides with the pin leaving idle
    AST_FIRST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        first_edge_o |-> (sclk_o != $past(idle_hi_i))); // R9

    // The first-edge marker is a single-cycle pulse
    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        first_edge_o |=> !first_edge_o); // R9

endmodule

// File: tb/test_clkb_gen.sv
`timescale 1ns/1ps
module test_clkb_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div = 8'd4;
    logic       idle = 1'b0;
    logic       we = 1'b0;
    logic [7:0] len = 8'd0;
    logic [7:0] lead = 8'd0;
    logic       sclk, busy, fedge, dstart;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkb_gen i_clkb_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .div_i        (div),
        .idle_hi_i    (idle),
        .burst_we_i   (we),
        .burst_len_i  (len),
        .lead_i       (lead),
        .sclk_o       (sclk),
        .busy_o       (busy),
        .first_edge_o (fedge),
        .data_start_o (dstart)
    );

    // {div, idle, len, lead, write cycle}
    localparam logic [39:0] VECS [0:7] = '{
        {8'd4, 8'd0, 8'd3, 8'd5,  8'd0},
        {8'd4, 8'd1, 8'd2, 8'd7,  8'd3},
        {8'd5, 8'd0, 8'd4, 8'd2,  8'd1},
        {8'd2, 8'd1, 8'd5, 8'd1,  8'd2},
        {8'd1, 8'd0, 8'd2, 8'd3,  8'd1},
        {8'd0, 8'd1, 8'd1, 8'd0,  8'd4},
        {8'd7, 8'd0, 8'd2, 8'd12, 8'd9},
        {8'd3, 8'd1, 8'd3, 8'd4,  8'd2}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Enable at cycle 0, write at cycle w, and watch the outputs for 100 cycles
    task automatic run_burst(input int dv, input int iv, input int n, input int ld, input int w,
                             input int xk, input int xlen, input int dropk,
                             output int fk, output int fcnt, output int dsk, output int dscnt,
                             output int rises, output int act, output int bfirst, output int blast,
                             output int frk, output int abort_ok);
        logic prev;
        fk = -1; fcnt = 0; dsk = -1; dscnt = 0; rises = 0; act = 0;
        bfirst = -1; blast = -1; frk = -1; abort_ok = 0;
        en = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        div = 8'(dv); idle = iv[0];
        @(negedge clk);
        en = 1'b1;
        repeat (w) @(negedge clk);
        we = 1'b1; len = 8'(n); lead = 8'(ld);
        prev = idle;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (fedge) begin fcnt++; if (fk < 0) fk = k; end
            if (dstart) begin dscnt++; if (dsk < 0) dsk = k; end
            if (sclk != idle) act++;
            if (prev == idle && sclk != idle) begin rises++; if (frk < 0) frk = k; end
            if (busy) begin if (bfirst < 0) bfirst = k; blast = k; end
            if (k == dropk + 1) abort_ok = (!busy && sclk == idle) ? 1 : 0;
            prev = sclk;
            if (k == 1) we = 1'b0;
            if (k == xk) begin we = 1'b1; len = 8'(xlen); lead = 8'd1; end
            if (k == xk + 1) we = 1'b0;
            if (k == dropk) en = 1'b0;
        end
    endtask

    initial begin
        #250000;
        if (!done) begin
            n_err++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok;
        // R1: reset state
        en = 1'b1; we = 1'b1; len = 8'd3;
        repeat (4) @(negedge clk);
        chk("R1", "sclk in reset", int'(sclk), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "first_edge in reset", int'(fedge), 0);
        chk("R1", "data_start in reset", int'(dstart), 0);
        en = 1'b0; we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            int dv, iv, n, ld, w, dc, p, gap, h;
            dv = int'(VECS[v][39:32]); iv = int'(VECS[v][31:24]); n = int'(VECS[v][23:16]);
            ld = int'(VECS[v][15:8]); w = int'(VECS[v][7:0]);
            dc = (dv < 2) ? 2 : dv;
            p = w % dc;
            gap = (p < dc - 1) ? (dc - 1 - p) : dc;
            h = (dc + 1) / 2;
            run_burst(dv, iv, n, ld, w, -1, 0, -1,
                      fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok);
            chk((dv < 2) ? "R5" : "R2", "first edge cycle", fk, gap + 2);
            if (w == 0) chk("R3", "earliest edge in second period", fk, dc + 1);
            chk("R4", "pulse count", rises, n);
            chk("R4", "active-level cycles", act, n * h);
            chk("R6", "busy rise", bfirst, 1);
            chk("R6", "busy last cycle", blast, gap + n * dc);
            chk("R8", "data_start count", dscnt, (ld > 0) ? 1 : 0);
            if (ld > 0) chk("R8", "data_start cycle", dsk, ld);
            chk("R9", "first_edge count", fcnt, 1);
            chk("R9", "first_edge aligned with pin", frk, fk);
        end

        // R7: second write in the middle of a burst is ignored
        run_burst(4, 0, 2, 20, 0, 3, 9, -1,
                  fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok);
        chk("R7", "pulses with write while busy", rises, 2);
        chk("R7", "data_start count with write while busy", dscnt, 1);
        chk("R7", "data_start cycle with write while busy", dsk, 20);
        chk("R7", "busy last with write while busy", blast, 11);

        // R7: zero-length write is ignored
        run_burst(4, 0, 0, 2, 1, -1, 0, -1,
                  fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok);
        chk("R7", "busy after zero-length write", bfirst, -1);
        chk("R7", "pulses after zero-length write", rises, 0);
        chk("R7", "data_start after zero-length write", dscnt, 0);

        // R7: write while disabled is ignored
        en = 1'b0; div = 8'd4; idle = 1'b0;
        @(negedge clk);
        we = 1'b1; len = 8'd3; lead = 8'd2;
        @(negedge clk);
        we = 1'b0; en = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (busy || sclk || dstart) seen++;
            end
            chk("R7", "activity after write while disabled", seen, 0);
        end

        // R10: dropping enable aborts the burst
        run_burst(4, 1, 5, 0, 0, -1, 0, 7,
                  fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok);
        chk("R10", "idle and not busy after abort", abort_ok, 1);
        chk("R10", "no pulses after abort", rises, 1);
        chk("R10", "busy last before abort", blast, 7);

        // R10: phase restarts after re-enable
        run_burst(3, 0, 1, 0, 2, -1, 0, -1,
                  fk, fcnt, dsk, dscnt, rises, act, bfirst, blast, frk, abort_ok);
        chk("R10", "first edge after re-enable", fk, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule